// File: doc/BRIEF.md
# Auxiliary I/O and Power-Control Register Block

This block is a small group of memory-mapped control registers in a workstation I/O controller. Software reaches them through a simple synchronous register bus. Each register has its own select line and an offset inside its window. Writes take effect at the clock edge where `bus_wr` is high. Reads return the selected register on `bus_rdata` in the same cycle, without registering. The bus always accepts a transfer and never pushes back, so it has no valid/ready pair: a transfer is any cycle where a select bit is high.

Some registers are plain storage. Several have side effects:
- a write can fire a floppy terminal-count pulse;
- a write can request shutdown or a system reset;
- a write can halt the CPU until the halt is acknowledged.

A power-fail input is synchronized and recorded as a status bit, subject to an enable in the configuration byte. That status bit drives an interrupt.

There are two resets:
- `rst_n` is a warm reset. It clears only the volatile control registers.
- `por_n` is the power-on reset. It clears everything, including the registers that survive a warm reset.

Top module: `auxctl_regs`

## Requirements
- R1: Select bit and offset map. `bus_sel` bit 0 selects configuration, bit 1 diagnostic, bit 2 modem-control, bit 3 LED, bit 4 system-control, bit 5 auxiliary-1, bit 6 auxiliary-2 and bit 7 CPU-idle. Each register lives at offset 0 of its window. At any other `bus_addr`, writes are ignored and reads return 0.
- R2: The configuration, diagnostic and modem-control bytes store `bus_wdata[7:0]` and read it back in `bus_rdata[7:0]`, with the upper bits reading 0.
- R3: A write to auxiliary-1 with data bit 1 set makes `fdc_tc` high for exactly the one cycle after the write edge. Bit 1 always reads as 0. The other seven bits are stored as written.
- R4: In auxiliary-2, only bit 0 (power-off) is stored from the write data. Bit 5 is the power-fail status, and an ordinary write leaves it unchanged. Every other bit, including bit 1, always reads as 0.
- R5: A write to auxiliary-2 with data bit 1 set clears the power-fail status (bit 5). In that same write, bit 0 is still stored.
- R6: A write to auxiliary-2 with data bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge.
- R7: `pfail_in` passes through a two-flop synchronizer. On each change of the synchronized level, the status bit is loaded with (new level AND configuration bit 3). The status is not re-evaluated while the level holds. When an input change and an auxiliary-2 clear reach the status in the same cycle, the input change wins.
- R8: `pfail_irq` is high exactly when auxiliary-2 bit 5 and configuration bit 3 are both 1.
- R9: A write to system-control at offset 0 with data bit 0 set loads the register with 0x00000002 and makes `reset_req` high for one cycle. A write with data bit 0 clear changes nothing.
- R10: The LED register stores `bus_wdata[15:0]` and reads it back, with bits 31:16 reading 0.
- R11: Any write to the CPU-idle register sets `cpu_halt`, whatever the data. `cpu_halt` stays high until a cycle with `halt_ack` high and no idle write. Reads of the CPU-idle register return 0.
- R12: Warm reset (`rst_n` low) clears configuration, auxiliary-1, auxiliary-2, modem-control, `cpu_halt` and the pulse outputs. The diagnostic byte, LED word and system-control word keep their values.
- R13: Power-on reset (`por_n` low) clears every register and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| bus_sel | input | 8 | One-hot register select |
| bus_addr | input | 2 | Offset within the selected window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pfail_in | input | 1 | Asynchronous power-fail level |
| halt_ack | input | 1 | Clears the CPU halt request |
| pfail_irq | output | 1 | Power-fail interrupt |
| fdc_tc | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | System reset request pulse |
| cpu_halt | output | 1 | CPU halt request, held until acknowledged |

## Verification
The properties take for granted the following about the inputs:
- At most one select bit is high in any cycle.
- No write happens during either reset.
- `bus_wdata` is held steady for the whole write cycle.

The stimulus keeps to these by driving a single select from a task that raises and drops it around one edge, and by issuing bus cycles only after both resets have been released.

The bench changes `pfail_in` only when the bus is idle, and waits at least four cycles before it samples the status. The input-wins collision from R7 is therefore left to the RTL's ordering rather than stressed.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
  localparam int NUM_REGIONS = 8;
  localparam int DATA_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int LED_W       = 16;

  typedef enum logic [2:0] {
    RG_CFG    = 3'd0,
    RG_DIAG   = 3'd1,
    RG_MODEM  = 3'd2,
    RG_LED    = 3'd3,
    RG_SYSCTL = 3'd4,
    RG_AUX1   = 3'd5,
    RG_AUX2   = 3'd6,
    RG_IDLE   = 3'd7
  } region_e;

  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int CFG_PFEN_BIT = 3;
  localparam int SYS_RST_BIT  = 0;
  localparam logic [DATA_W-1:0] SYS_RSTSTAT = 32'h0000_0002;
endpackage

// File: rtl/auxctl_sync.sv
module auxctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_warm,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst_warm) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/auxctl_power.sv
module auxctl_power
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_warm,
  input  logic              pf_level,
  input  logic              pf_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] aux2_rd,
  output logic              irq,
  output logic              shutdown
);
  logic off_q, status_q, level_prev_q, shut_q;

  always_ff @(posedge clk) begin
    if (rst_warm) begin
      off_q        <= 1'b0;
      status_q     <= 1'b0;
      level_prev_q <= 1'b0;
      shut_q       <= 1'b0;
    end else begin
      level_prev_q <= pf_level;
      shut_q       <= wr_en & wr_byte[AUX2_OFF_BIT];
      if (wr_en) begin
        off_q <= wr_byte[AUX2_OFF_BIT];
        if (wr_byte[AUX2_CLR_BIT]) status_q <= 1'b0;
      end
      // a level change on the synchronized input overrides a software clear
      if (pf_level != level_prev_q) status_q <= pf_level & pf_en;
    end
  end

  always_comb begin
    aux2_rd               = '0;
    aux2_rd[AUX2_OFF_BIT] = off_q;
    aux2_rd[AUX2_PF_BIT]  = status_q;
  end

  assign irq      = status_q & pf_en;
  assign shutdown = shut_q;
endmodule

// File: rtl/auxctl_retain.sv
module auxctl_retain
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              diag_wr,
  input  logic              led_wr,
  input  logic              sys_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [BYTE_W-1:0] diag_q,
  output logic [LED_W-1:0]  led_q,
  output logic [DATA_W-1:0] sys_q,
  output logic              rst_pulse
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      diag_q    <= '0;
      led_q     <= '0;
      sys_q     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= sys_wr & wdata[SYS_RST_BIT];
      if (diag_wr)                     diag_q <= wdata[BYTE_W-1:0];
      if (led_wr)                      led_q  <= wdata[LED_W-1:0];
      if (sys_wr && wdata[SYS_RST_BIT]) sys_q <= SYS_RSTSTAT;
    end
  end
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
  import auxctl_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   por_n,
  input  logic [NUM_REGIONS-1:0] bus_sel,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   pfail_in,
  input  logic                   halt_ack,
  output logic                   pfail_irq,
  output logic                   fdc_tc,
  output logic                   shutdown_req,
  output logic                   reset_req,
  output logic                   cpu_halt
);
  logic                   rst_warm;
  logic                   at_base;
  logic [NUM_REGIONS-1:0] wr_hit;
  logic [DATA_W-1:0]      rd_val [NUM_REGIONS];

  logic [BYTE_W-1:0] cfg_q, aux1_q, modem_q, aux2_rd, diag_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic              tc_q, halt_q, pf_level;

  assign rst_warm = !rst_n || !por_n;
  assign at_base  = (bus_addr == '0);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
    assign wr_hit[g] = bus_wr & bus_sel[g] & at_base;
  end

  always_ff @(posedge clk) begin
    if (rst_warm) begin
      cfg_q   <= '0;
      aux1_q  <= '0;
      modem_q <= '0;
      tc_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      tc_q <= wr_hit[RG_AUX1] & bus_wdata[AUX1_TC_BIT];
      if (wr_hit[RG_CFG])   cfg_q   <= bus_wdata[BYTE_W-1:0];
      if (wr_hit[RG_MODEM]) modem_q <= bus_wdata[BYTE_W-1:0];
      if (wr_hit[RG_AUX1]) begin
        aux1_q              <= bus_wdata[BYTE_W-1:0];
        aux1_q[AUX1_TC_BIT] <= 1'b0;
      end
      if (wr_hit[RG_IDLE])  halt_q <= 1'b1;
      else if (halt_ack)    halt_q <= 1'b0;
    end
  end

  auxctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_warm (rst_warm),
    .d        (pfail_in),
    .q        (pf_level)
  );

  auxctl_power u_power (
    .clk      (clk),
    .rst_warm (rst_warm),
    .pf_level (pf_level),
    .pf_en    (cfg_q[CFG_PFEN_BIT]),
    .wr_en    (wr_hit[RG_AUX2]),
    .wr_byte  (bus_wdata[BYTE_W-1:0]),
    .aux2_rd  (aux2_rd),
    .irq      (pfail_irq),
    .shutdown (shutdown_req)
  );

  auxctl_retain u_retain (
    .clk       (clk),
    .por_n     (por_n),
    .diag_wr   (wr_hit[RG_DIAG]),
    .led_wr    (wr_hit[RG_LED]),
    .sys_wr    (wr_hit[RG_SYSCTL]),
    .wdata     (bus_wdata),
    .diag_q    (diag_q),
    .led_q     (led_q),
    .sys_q     (sys_q),
    .rst_pulse (reset_req)
  );

  always_comb begin
    rd_val[RG_CFG]    = DATA_W'(cfg_q);
    rd_val[RG_DIAG]   = DATA_W'(diag_q);
    rd_val[RG_MODEM]  = DATA_W'(modem_q);
    rd_val[RG_LED]    = DATA_W'(led_q);
    rd_val[RG_SYSCTL] = sys_q;
    rd_val[RG_AUX1]   = DATA_W'(aux1_q);
    rd_val[RG_AUX2]   = DATA_W'(aux2_rd);
    rd_val[RG_IDLE]   = '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (bus_sel[i] && at_base) bus_rdata = bus_rdata | rd_val[i];
  end

  assign fdc_tc   = tc_q;
  assign cpu_halt = halt_q;
endmodule

// File: rtl/auxctl_checker.sv
module auxctl_checker
  import auxctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   por_n,
  input logic [NUM_REGIONS-1:0] bus_sel,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic                   halt_ack,
  input logic                   pfail_irq,
  input logic                   fdc_tc,
  input logic                   shutdown_req,
  input logic                   reset_req,
  input logic                   cpu_halt
);
  logic off_ok;
  assign off_ok = (bus_addr == '0);

  a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0(bus_sel));

  a_r1_offset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !off_ok |-> bus_rdata == '0);

  a_r3_tc_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_sel[RG_AUX1] && off_ok && $onehot0(bus_sel)) |-> !bus_rdata[AUX1_TC_BIT]);

  a_r3_tc_has_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    fdc_tc |-> $past(bus_wr && bus_sel[RG_AUX1] && off_ok && bus_wdata[AUX1_TC_BIT]));

  a_r4_aux2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_sel == (NUM_REGIONS'(1) << RG_AUX2) && off_ok) |-> (bus_rdata & ~32'h21) == '0);

  a_r6_shutdown_follows: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_sel[RG_AUX2] && off_ok && bus_wdata[AUX2_OFF_BIT]) |=> shutdown_req);

  a_r8_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_sel[RG_CFG] && off_ok && !bus_wdata[CFG_PFEN_BIT]) |=> !pfail_irq);

  a_r9_reset_req_follows: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_sel[RG_SYSCTL] && off_ok && bus_wdata[SYS_RST_BIT]) |=> reset_req);

  a_r11_halt_set: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_sel[RG_IDLE] && off_ok) |=> cpu_halt);

  a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cpu_halt && !halt_ack) |=> cpu_halt);

  a_r11_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_sel == (NUM_REGIONS'(1) << RG_IDLE)) |-> bus_rdata == '0);
endmodule

bind auxctl_regs auxctl_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_n        (por_n),
  .bus_sel      (bus_sel),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .halt_ack     (halt_ack),
  .pfail_irq    (pfail_irq),
  .fdc_tc       (fdc_tc),
  .shutdown_req (shutdown_req),
  .reset_req    (reset_req),
  .cpu_halt     (cpu_halt)
);

// File: tb/test_auxctl_regs.sv
`timescale 1ns/1ps
module test_auxctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [7:0]  bus_sel = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pfail_in = 1'b0, halt_ack = 1'b0;
  logic        pfail_irq, fdc_tc, shutdown_req, reset_req, cpu_halt;
  int          total = 0, bad = 0;
  logic [31:0] rv;

  localparam int CFG = 0, DIAG = 1, MDM = 2, LED = 3, SYS = 4, AUX1 = 5, AUX2 = 6, IDLE = 7;

  always #10 clk = ~clk;

  auxctl_regs i_auxctl_regs (.*);

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        exp_tc;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd0, 32'h0000_00A5, 32'h0000_00A5, 1'b0},  // R2 cfg
    '{3'd1, 32'hFFFF_FF3C, 32'h0000_003C, 1'b0},  // R2 diag
    '{3'd2, 32'h0000_00FF, 32'h0000_00FF, 1'b0},  // R2 modem
    '{3'd3, 32'h1234_BEEF, 32'h0000_BEEF, 1'b0},  // R10 LED
    '{3'd5, 32'h0000_00FF, 32'h0000_00FD, 1'b1},  // R3 aux1 with tc
    '{3'd5, 32'h0000_0041, 32'h0000_0041, 1'b0},  // R3 aux1 no tc
    '{3'd6, 32'h0000_00FC, 32'h0000_0000, 1'b0},  // R4 aux2 masked
    '{3'd4, 32'h0000_0000, 32'h0000_0000, 1'b0},  // R9 no bit0
    '{3'd4, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0},  // R9 reset status
    '{3'd0, 32'h0000_0008, 32'h0000_0008, 1'b0}   // R2 cfg enable
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [1:0] off, logic [31:0] d);
    @(negedge clk);
    bus_sel = 8'(1 << idx); bus_addr = off; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_sel = '0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
  endtask

  task automatic rd(int idx, logic [1:0] off, output logic [31:0] v);
    bus_sel = 8'(1 << idx); bus_addr = off;
    #2 v = bus_rdata;
    bus_sel = '0; bus_addr = '0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R13 power-on state
    rd(DIAG, 0, rv); chk("R13 diag after por", rv, 0);
    rd(SYS, 0, rv);  chk("R13 sysctl after por", rv, 0);
    rd(CFG, 0, rv);  chk("R13 cfg after por", rv, 0);
    chk("R13 outputs after por", {27'd0, pfail_irq, fdc_tc, shutdown_req, reset_req, cpu_halt}, 0);

    foreach (VECS[i]) begin
      wr(int'(VECS[i].idx), 0, VECS[i].wd);
      chk($sformatf("R3 tc pulse vec%0d", i), {31'd0, fdc_tc}, {31'd0, VECS[i].exp_tc});
      rd(int'(VECS[i].idx), 0, rv);
      chk($sformatf("R2/R3/R4/R9/R10 readback vec%0d", i), rv, VECS[i].exp);
    end
    @(negedge clk);
    chk("R3 tc one cycle only", {31'd0, fdc_tc}, 0);

    // R9 reset request pulse
    wr(SYS, 0, 32'h1);
    chk("R9 reset_req pulse", {31'd0, reset_req}, 1);
    @(negedge clk);
    chk("R9 reset_req ends", {31'd0, reset_req}, 0);

    // R7/R8 power-fail with enable set (cfg = 0x08)
    pfail_in = 1'b1; repeat (4) @(negedge clk);
    rd(AUX2, 0, rv); chk("R7 status set", rv, 32'h20);
    chk("R8 irq high", {31'd0, pfail_irq}, 1);
    wr(AUX2, 0, 32'h0);
    rd(AUX2, 0, rv); chk("R4 status kept on write", rv, 32'h20);
    wr(AUX2, 0, 32'h3);
    chk("R6 shutdown pulse", {31'd0, shutdown_req}, 1);
    rd(AUX2, 0, rv); chk("R5 clear keeps power-off only", rv, 32'h01);
    chk("R8 irq low after clear", {31'd0, pfail_irq}, 0);
    @(negedge clk);
    chk("R6 shutdown one cycle", {31'd0, shutdown_req}, 0);
    repeat (4) @(negedge clk);
    rd(AUX2, 0, rv); chk("R7 held level no re-set", rv, 32'h01);
    pfail_in = 1'b0; repeat (4) @(negedge clk);
    wr(CFG, 0, 32'h0);
    pfail_in = 1'b1; repeat (4) @(negedge clk);
    rd(AUX2, 0, rv); chk("R7 gated by enable", rv, 32'h01);
    wr(CFG, 0, 32'h8);
    pfail_in = 1'b0; repeat (4) @(negedge clk);
    pfail_in = 1'b1; repeat (4) @(negedge clk);
    chk("R8 irq after re-arm", {31'd0, pfail_irq}, 1);
    wr(CFG, 0, 32'h0);
    chk("R8 irq drops with enable", {31'd0, pfail_irq}, 0);
    rd(AUX2, 0, rv); chk("R8 status kept", rv, 32'h21);
    pfail_in = 1'b0; repeat (4) @(negedge clk);
    rd(AUX2, 0, rv); chk("R7 falling clears", rv, 32'h01);

    // R11 halt
    wr(IDLE, 0, 32'h0);
    chk("R11 halt set", {31'd0, cpu_halt}, 1);
    rd(IDLE, 0, rv); chk("R11 idle reads 0", rv, 0);
    repeat (3) @(negedge clk);
    chk("R11 halt held", {31'd0, cpu_halt}, 1);
    halt_ack = 1'b1; @(negedge clk); halt_ack = 1'b0;
    chk("R11 halt cleared", {31'd0, cpu_halt}, 0);

    // R1 other offsets
    wr(DIAG, 2, 32'h99);
    rd(DIAG, 0, rv); chk("R1 offset write ignored", rv, 32'h3C);
    rd(SYS, 1, rv);  chk("R1 offset reads zero", rv, 0);

    // R12 warm reset
    wr(MDM, 0, 32'h5A);
    wr(IDLE, 0, 32'h0);
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(MDM, 0, rv);  chk("R12 modem cleared", rv, 0);
    rd(AUX1, 0, rv); chk("R12 aux1 cleared", rv, 0);
    rd(AUX2, 0, rv); chk("R12 aux2 cleared", rv, 0);
    chk("R12 halt cleared", {31'd0, cpu_halt}, 0);
    rd(DIAG, 0, rv); chk("R12 diag kept", rv, 32'h3C);
    rd(LED, 0, rv);  chk("R12 led kept", rv, 32'hBEEF);
    rd(SYS, 0, rv);  chk("R12 sysctl kept", rv, 32'h2);

    // R13 power-on reset clears retained registers
    por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd(LED, 0, rv); chk("R13 led cleared", rv, 0);
    rd(SYS, 0, rv); chk("R13 sysctl cleared", rv, 0);
    report();
  end
endmodule